// File: doc/BRIEF.md
# Output-Queue Emulating Timestamp Allocator

This block schedules flits in a five-port router as if the router had ideal output queues. Each input (north, south, east, west, local) can present one request per cycle. A request names the output port the flit wants. The block answers with a departure cycle, called a timestamp. The timestamp is the cycle in which that flit would leave a router with unlimited buffering at each output. Later pipeline stages park the flit and release it when the shared time counter reaches its timestamp. Because of this, each output drains in first-come-first-served order, with no per-cycle switch matching.

Each output keeps a register that holds the earliest slot not yet booked. A request receives the later of two values: that register, or the cycle after the current one. The register then moves past every slot handed out. A flit that lost a later allocation step comes back with the retry flag set. It is treated as a new request and is given a fresh, later slot. Within one cycle, retried flits are ordered ahead of new ones. A stall flag for each output limits how far into the future slots may be booked. This bound is the buffering horizon.

Top module: `oqe_top`

## Requirements
- R1: `cur_time` is 0 during reset and increases by one every clock afterwards, wrapping modulo 256.
- R2: A granted request made while `cur_time` = T receives, on the next cycle, timestamp max(T+1, next free slot of its output), computed modulo 256. That timestamp is no more than HORIZON-1 slots beyond T+1.
- R3: Timestamps handed out on one output never repeat within the horizon, and they increase by exactly one per grant in arrival order.
- R4: Requests to the same output in one cycle get consecutive slots. Retried requests (`req_retry`=1) are ordered first, then new ones. Within each group, the lower input index comes first.
- R5: `stall[o]` is high while the number of slots booked on output o beyond the next cycle is at least HORIZON. A request that would need a slot at or beyond that limit gets no grant.
- R6: `grant[i]` rises exactly one cycle after a valid, grantable request on input i, and is low when there was no valid request.
- R7: During reset and on the first cycle after it, every grant and stall output is low.
- R8: After an idle gap of any length, including one longer than half the time range, the next request gets timestamp T+1.
- R9: A retried flit receives a timestamp later than every slot already booked on its output; a slot is never handed out twice.
- R10: Output codes are north=0, south=1, east=2, west=3, local=4. Codes 5 to 7 are ignored: no grant, and no slot is booked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 5 | Request present, one bit per input |
| req_out | input | 15 | Requested output code, 3 bits per input (input i at bits 3i+2:3i) |
| req_retry | input | 5 | Request is a re-request after a failed later allocation |
| grant | output | 5 | Timestamp issued, one cycle after the request |
| grant_ts | output | 40 | Issued timestamp, 8 bits per input (input i at bits 8i+7:8i) |
| cur_time | output | 8 | Free-running current time |
| stall | output | 5 | Output's booking horizon is full |

## Verification
A wrong next-free register shows up at the ports on the very next grant to that output. It appears as a timestamp that repeats, skips or falls behind the time counter, or as a stall flag that disagrees with the number of slots booked. A wrong priority among inputs shows up in the same cycle that several requests meet on one output: the slots come out swapped. An idle gap longer than half the time range exposes any failure to bring a stale register forward. It does so on the first request after the gap.

// File: rtl/oqe_pkg.sv
package oqe_pkg;

    localparam int NPORT = 5;
    localparam int TSW   = 8;
    localparam int DSTW  = 3;
    localparam int CNTW  = $clog2(NPORT + 1);

    typedef logic [TSW-1:0]  stamp_t;
    typedef logic [DSTW-1:0] dst_t;
    typedef logic [CNTW-1:0] cnt_t;

    typedef enum logic [DSTW-1:0] {
        DIR_NORTH = 3'd0,
        DIR_SOUTH = 3'd1,
        DIR_EAST  = 3'd2,
        DIR_WEST  = 3'd3,
        DIR_LOCAL = 3'd4
    } dir_e;

    typedef struct packed {
        logic vld;
        logic retry;
        dst_t dst;
    } req_t;

    typedef struct packed {
        logic   vld;
        stamp_t ts;
    } gnt_t;

    // legal output code
    function automatic logic dst_ok(input dst_t d);
        return (int'(d) < NPORT);
    endfunction

    // later of two stamps inside a half-range window
    function automatic stamp_t stamp_later(input stamp_t a, input stamp_t b);
        stamp_t diff;
        diff = a - b;
        return diff[TSW-1] ? b : a;
    endfunction

endpackage

// File: rtl/oqe_clock.sv
module oqe_clock
    import oqe_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output stamp_t now
);
    always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + stamp_t'(1);
    end
endmodule

// File: rtl/oqe_rank.sv
// Position of each request among those aimed at the same output:
// retried requests first, then by input index.
module oqe_rank
    import oqe_pkg::*;
(
    input  req_t reqs [NPORT],
    output cnt_t rank [NPORT]
);
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            rank[i] = '0;
            for (int k = 0; k < NPORT; k++) begin
                if (k != i && reqs[k].vld && reqs[k].dst == reqs[i].dst) begin
                    if ((reqs[k].retry && !reqs[i].retry) ||
                        (reqs[k].retry == reqs[i].retry && k < i))
                        rank[i] = rank[i] + cnt_t'(1);
                end
            end
        end
    end
endmodule

// File: rtl/oqe_slot.sv
// Per-output next-free-slot keeper with horizon limit.
module oqe_slot
    import oqe_pkg::*;
#(
    parameter int HORIZON = 8
)(
    input  logic   clk,
    input  logic   rst,
    input  stamp_t now,
    input  cnt_t   demand,
    output stamp_t base,
    output stamp_t room,
    output logic   full
);
    localparam stamp_t LIMIT = stamp_t'(HORIZON);

    stamp_t nf_q;
    stamp_t soonest;
    stamp_t offset;
    stamp_t taken;

    always_comb begin
        soonest = now + stamp_t'(1);
        base    = stamp_later(soonest, nf_q);
        offset  = base - soonest;
        full    = (offset >= LIMIT);
        room    = full ? '0 : (LIMIT - offset);
        taken   = (stamp_t'(demand) < room) ? stamp_t'(demand) : room;
    end

    // stale registers are pulled up to the present every cycle
    always_ff @(posedge clk) begin
        if (rst) nf_q <= '0;
        else     nf_q <= base + taken;
    end
endmodule

// File: rtl/oqe_top.sv
module oqe_top
    import oqe_pkg::*;
#(
    parameter int HORIZON = 8
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPORT-1:0]      req_valid,
    input  logic [NPORT*DSTW-1:0] req_out,
    input  logic [NPORT-1:0]      req_retry,
    output logic [NPORT-1:0]      grant,
    output logic [NPORT*TSW-1:0]  grant_ts,
    output logic [TSW-1:0]        cur_time,
    output logic [NPORT-1:0]      stall
);
    req_t   reqs   [NPORT];
    cnt_t   rank   [NPORT];
    cnt_t   demand [NPORT];
    stamp_t base   [NPORT];
    stamp_t room   [NPORT];
    gnt_t   gnt_d  [NPORT];
    gnt_t   gnt_q  [NPORT];
    stamp_t now;

    oqe_clock u_clock (.clk(clk), .rst(rst), .now(now));
    assign cur_time = now;

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        always_comb begin
            reqs[i].vld   = req_valid[i] && dst_ok(req_out[i*DSTW +: DSTW]);
            reqs[i].retry = req_retry[i];
            reqs[i].dst   = req_out[i*DSTW +: DSTW];
        end
    end

    oqe_rank u_rank (.reqs(reqs), .rank(rank));

    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            demand[o] = '0;
            for (int i = 0; i < NPORT; i++)
                if (reqs[i].vld && int'(reqs[i].dst) == o)
                    demand[o] = demand[o] + cnt_t'(1);
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        oqe_slot #(.HORIZON(HORIZON)) u_slot (
            .clk    (clk),
            .rst    (rst),
            .now    (now),
            .demand (demand[o]),
            .base   (base[o]),
            .room   (room[o]),
            .full   (stall[o])
        );
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_gnt
        always_comb begin
            stamp_t sel_base;
            stamp_t sel_room;
            sel_base = '0;
            sel_room = '0;
            for (int o = 0; o < NPORT; o++) begin
                if (int'(reqs[i].dst) == o) begin
                    sel_base = base[o];
                    sel_room = room[o];
                end
            end
            gnt_d[i].vld = reqs[i].vld && (stamp_t'(rank[i]) < sel_room);
            gnt_d[i].ts  = sel_base + stamp_t'(rank[i]);
        end

        always_ff @(posedge clk) begin
            if (rst) gnt_q[i] <= '0;
            else     gnt_q[i] <= gnt_d[i];
        end

        assign grant[i]               = gnt_q[i].vld;
        assign grant_ts[i*TSW +: TSW] = gnt_q[i].ts;
    end

endmodule

// File: rtl/oqe_checker.sv
module oqe_checker
    import oqe_pkg::*;
#(
    parameter int HORIZON = 8
)(
    input logic                  clk,
    input logic                  rst,
    input logic [NPORT-1:0]      req_valid,
    input logic [NPORT*DSTW-1:0] req_out,
    input logic [NPORT-1:0]      req_retry,
    input logic [NPORT-1:0]      grant,
    input logic [NPORT*TSW-1:0]  grant_ts,
    input logic [TSW-1:0]        cur_time,
    input logic [NPORT-1:0]      stall
);
    logic [NPORT-1:0] legal;
    logic [NPORT-1:0] hits_stall;

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            legal[i]      = req_valid[i] && dst_ok(req_out[i*DSTW +: DSTW]);
            hits_stall[i] = 1'b0;
            for (int o = 0; o < NPORT; o++)
                if (int'(req_out[i*DSTW +: DSTW]) == o && stall[o])
                    hits_stall[i] = legal[i];
        end
    end

    AST_TIME_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cur_time == $past(cur_time) + 8'd1);  // R1

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (grant == '0 && cur_time == '0));  // R7

    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        AST_NO_REQ_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
            !legal[i] |=> !grant[i]);  // R6

        AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
            hits_stall[i] |=> !grant[i]);  // R5

        AST_TS_WINDOW: assert property (@(posedge clk) disable iff (rst)
            grant[i] |-> (stamp_t'(grant_ts[i*TSW +: TSW] - cur_time) < stamp_t'(HORIZON)));  // R2

        for (genvar j = i + 1; j < NPORT; j++) begin : g_pair
            AST_NO_DUP_SLOT: assert property (@(posedge clk) disable iff (rst)
                (grant[i] && grant[j] &&
                 $past(req_out[i*DSTW +: DSTW]) == $past(req_out[j*DSTW +: DSTW]))
                |-> grant_ts[i*TSW +: TSW] != grant_ts[j*TSW +: TSW]);  // R3
        end
    end
endmodule

bind oqe_top oqe_checker #(.HORIZON(HORIZON)) u_oqe_checker (.*);

// File: tb/tb_oqe_top.sv
module tb_oqe_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 5;
    localparam int H  = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] req_valid;
    logic [NP*3-1:0] req_out;
    logic [NP-1:0] req_retry;
    logic [NP-1:0] grant;
    logic [NP*8-1:0] grant_ts;
    logic [7:0]    cur_time;
    logic [NP-1:0] stall;

    always #(CLK_PERIOD/2) clk = ~clk;

    oqe_top #(.HORIZON(H)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_out(req_out),
        .req_retry(req_retry), .grant(grant), .grant_ts(grant_ts),
        .cur_time(cur_time), .stall(stall)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int tnow;
    int nf  [NP];
    bit eg  [NP];
    int ets [NP];
    int v [NP];
    int d [NP];
    int r [NP];

    task automatic fail_line(input string tag, input int act, input int exp);
        n_bad++;
        $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    endtask

    task automatic cmp(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) fail_line(tag, act, exp);
    endtask

    function automatic int eff_slot(input int o);
        return (nf[o] > tnow + 1) ? nf[o] : tnow + 1;
    endfunction

    // compare every output against the model
    task automatic check_outputs();
        cmp("R1 cur_time", int'(cur_time), tnow % 256);
        for (int o = 0; o < NP; o++)
            cmp("R5 stall", int'(stall[o]), (eff_slot(o) - (tnow + 1) >= H) ? 1 : 0);
        for (int i = 0; i < NP; i++) begin
            cmp("R6 grant", int'(grant[i]), int'(eg[i]));
            // R3 R4 R9: slot ordering shows in the stamp value
            if (eg[i] && grant[i])
                cmp("R2 timestamp", int'(grant_ts[i*8 +: 8]), ets[i] % 256);
        end
    endtask

    // behavioural reference: ideal output queue per port, unbounded time
    task automatic model_step();
        for (int i = 0; i < NP; i++) begin
            eg[i] = 0;
            ets[i] = 0;
        end
        for (int o = 0; o < NP; o++) begin
            int base;
            int cnt;
            base = eff_slot(o);
            cnt = 0;
            for (int pass = 0; pass < 2; pass++)
                for (int i = 0; i < NP; i++)
                    if (v[i] != 0 && d[i] == o && r[i] == (pass == 0 ? 1 : 0)) begin
                        if (base + cnt - (tnow + 1) < H) begin
                            eg[i] = 1;
                            ets[i] = base + cnt;
                            cnt++;
                        end
                    end
            nf[o] = base + cnt;
        end
        tnow++;
    endtask

    task automatic do_cycle();
        check_outputs();
        for (int i = 0; i < NP; i++) begin
            req_valid[i] = (v[i] != 0);
            req_out[i*3 +: 3] = 3'(d[i]);
            req_retry[i] = (r[i] != 0);
        end
        model_step();
        @(negedge clk);
    endtask

    task automatic clear_reqs();
        for (int i = 0; i < NP; i++) begin
            v[i] = 0; d[i] = 0; r[i] = 0;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        fail_line("R6 watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = '0;
        req_out = '0;
        req_retry = '0;
        clear_reqs();
        tnow = 0;
        for (int o = 0; o < NP; o++) nf[o] = 0;
        for (int i = 0; i < NP; i++) begin eg[i] = 0; ets[i] = 0; end
        repeat (3) @(negedge clk);
        // R7: quiet reset state
        cmp("R7 reset grant", int'(grant), 0);
        cmp("R7 reset stall", int'(stall), 0);
        cmp("R1 reset time", int'(cur_time), 0);
        rst = 1'b0;

        // single requests to different outputs (R2, R6)
        clear_reqs(); v[0] = 1; d[0] = 2; do_cycle();
        clear_reqs(); v[3] = 1; d[3] = 4; do_cycle();
        clear_reqs(); do_cycle();

        // all inputs to east at once: consecutive slots by index (R4)
        clear_reqs();
        for (int i = 0; i < NP; i++) begin v[i] = 1; d[i] = 2; end
        do_cycle();
        clear_reqs(); do_cycle();

        // retried flits ahead of new ones on north (R4, R9)
        clear_reqs();
        v[0] = 1; d[0] = 0;
        v[1] = 1; d[1] = 0;
        v[3] = 1; d[3] = 0; r[3] = 1;
        v[4] = 1; d[4] = 0; r[4] = 1;
        do_cycle();
        clear_reqs(); v[2] = 1; d[2] = 0; r[2] = 1; do_cycle();
        clear_reqs(); do_cycle();

        // saturate south until the horizon fills (R5, R3)
        for (int c = 0; c < 5; c++) begin
            clear_reqs();
            for (int i = 0; i < NP; i++) begin v[i] = 1; d[i] = 1; end
            do_cycle();
        end
        clear_reqs(); for (int c = 0; c < 10; c++) do_cycle();

        // illegal codes are ignored (R10)
        clear_reqs();
        v[0] = 1; d[0] = 5;
        v[1] = 1; d[1] = 6;
        v[2] = 1; d[2] = 7; r[2] = 1;
        v[3] = 1; d[3] = 3;
        do_cycle();
        clear_reqs(); do_cycle();

        // long idle gap across the wrap point (R8)
        clear_reqs(); v[1] = 1; d[1] = 3; v[2] = 1; d[2] = 3; do_cycle();
        clear_reqs(); for (int c = 0; c < 300; c++) do_cycle();
        clear_reqs(); v[4] = 1; d[4] = 3; do_cycle();
        clear_reqs(); do_cycle();

        // mixed random traffic
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < NP; i++) begin
                v[i] = ($urandom % 3 != 0) ? 1 : 0;
                d[i] = int'($urandom % 6);
                r[i] = ($urandom % 4 == 0) ? 1 : 0;
            end
            do_cycle();
        end
        clear_reqs();
        for (int c = 0; c < 12; c++) do_cycle();

        summary();
        $finish;
    end
endmodule